// File: doc/BRIEF.md
# Memory Dependence Tracker

This block sits beside the issue queue of an out-of-order core and decides when each in-flight load and store may go to memory. Every memory operation and every memory fence is entered into a fixed table, keyed by its sequence number. When a load or store is entered, the block picks the older operation it must wait for, which is called the producer. An active fence always supplies the producer. Without one, an external dependence predictor is asked, by instruction address. The new entry is then linked to that producer. An entry is offered to the issue queue only once both of its conditions hold: its source registers are ready, and its memory dependence has resolved.

When a store or fence completes, every entry linked to it has its memory dependence resolved, and the completing entry is freed. A full fence holds back both loads and stores. A write fence holds back stores only. A fence's hold is released only by the completion of the fence that set it. A squash removes all entries younger than a given sequence number and passes that number on to the predictor. Entries that had to be rescheduled wait in a replay set, and a replay request releases all of them at once. Entered stores and ordering violations are reported to the predictor.

Top module: `mem_dep_tracker`

## Requirements
- R1: After reset the table is empty and `ins_ready` is high. With all N_ENT entries in use, `ins_ready` is low, and an insert offered in that state is dropped and never appears on the ready output.
- R2: A load or store whose producer is zero, or not present in the table, is memory-ready at once. If its registers are ready at insert, it appears on the ready output in the next cycle.
- R3: A load or store linked to a present producer is not offered, even with its registers ready, until that producer completes. It is offered after that completion once its registers are also ready.
- R4: `ins_kind` encodes 0 as load, 1 as store, 2 as full fence and 3 as write fence. While a full fence is active, inserted loads and stores take the fence's sequence number as producer, and `pred_lookup_valid` stays low for them.
- R5: A write fence makes later stores wait on it. Later loads still consult the predictor and are not held by the write fence.
- R6: Completing a fence clears a hold flag only if the flag still carries that fence's sequence number. A younger fence therefore keeps its hold.
- R7: A load is never a producer. A predictor answer naming a load leaves the new entry memory-ready, and completing a load resolves no other entry.
- R8: A squash with value N removes every entry with sequence number above N, including pending and replay-waiting ones. It drives `pred_squash_valid` and `pred_squash_seq` = N in the same cycle.
- R9: A reschedule request parks an entry in the replay set, where it is not offered. A replay request offers every parked entry.
- R10: At most one entry is offered per cycle, the pending entry with the smallest sequence number. It stays offered until `rdy_accept` is high in a cycle where `rdy_valid` is high.
- R11: Each accepted store insert drives `st_rep_valid` with its address and sequence number in the same cycle. A violation input is passed to the predictor outputs in the same cycle.
- R12: If a producer completes in the same cycle that a dependent of it is inserted, the dependent is treated as having no dependence.
- R13: Fence entries are never offered on the ready output, even after a register-ready event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Table has a free entry |
| ins_kind | input | 2 | 0 load, 1 store, 2 full fence, 3 write fence |
| ins_seq | input | SEQ_W | Sequence number of the inserted operation |
| ins_pc | input | PC_W | Instruction address of the inserted operation |
| ins_regs_ok | input | 1 | Source registers already ready at insert |
| pred_lookup_valid | output | 1 | Predictor lookup request |
| pred_lookup_pc | output | PC_W | Lookup address |
| pred_lookup_seq | input | SEQ_W | Predicted producer, combinational answer (0 = none) |
| st_rep_valid | output | 1 | Store inserted report |
| st_rep_pc | output | PC_W | Reported store address |
| st_rep_seq | output | SEQ_W | Reported store sequence number |
| viol_valid | input | 1 | Ordering violation detected |
| viol_load_pc | input | PC_W | Address of the violating load |
| viol_store_pc | input | PC_W | Address of the conflicting store |
| pred_viol_valid | output | 1 | Violation forwarded to predictor |
| pred_viol_load_pc | output | PC_W | Forwarded load address |
| pred_viol_store_pc | output | PC_W | Forwarded store address |
| regs_valid | input | 1 | Register-ready event |
| regs_seq | input | SEQ_W | Entry whose registers became ready |
| done_valid | input | 1 | Completion event |
| done_seq | input | SEQ_W | Completing entry |
| resched_valid | input | 1 | Reschedule request |
| resched_seq | input | SEQ_W | Entry to park for replay |
| replay_req | input | 1 | Release all parked entries |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries above this number are removed |
| pred_squash_valid | output | 1 | Squash forwarded to predictor |
| pred_squash_seq | output | SEQ_W | Forwarded squash number |
| rdy_valid | output | 1 | An entry is offered for issue |
| rdy_seq | output | SEQ_W | Sequence number of the offered entry |
| rdy_is_store | output | 1 | Offered entry is a store |
| rdy_accept | input | 1 | Issue queue takes the offered entry |

## Verification
The sensitive collision is a producer completing in the same cycle as a new dependent naming it is inserted. The bench drives the completion and the insert in one cycle. It expects the load on the ready output in the next cycle rather than stranded waiting on a freed slot. A fence completing while a younger fence is still present is also provoked, and a later load must keep waiting. A squash that overlaps pending entries is checked the same way, with only the survivors allowed on the ready output. A behavioural model kept as a queue of entries is compared against the outputs every cycle.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    typedef enum logic [1:0] {
        K_LOAD    = 2'd0,
        K_STORE   = 2'd1,
        K_FULLBAR = 2'd2,
        K_WRBAR   = 2'd3
    } kind_e;
endpackage

// File: rtl/mdu_seq_cam.sv
// Sequence-number match across the table; first eligible hit wins.
module mdu_seq_cam #(
    parameter int N_ENT = 16,
    parameter int SEQ_W = 16,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] elig,
    input  logic [SEQ_W-1:0] seqs [N_ENT],
    input  logic [SEQ_W-1:0] key,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!hit && elig[i] && seqs[i] == key) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mdu_oldest_pick.sv
// Selects the candidate with the smallest sequence number.
module mdu_oldest_pick #(
    parameter int N_ENT = 16,
    parameter int SEQ_W = 16,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] cand,
    input  logic [SEQ_W-1:0] seqs [N_ENT],
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [SEQ_W-1:0] best;
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (cand[i] && (!any || seqs[i] < best)) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = seqs[i];
            end
        end
    end
endmodule

// File: rtl/mdu_barrier_regs.sv
// Load-hold and store-hold flags, each tagged with the fence that set it.
module mdu_barrier_regs #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_full,
    input  logic             set_wr,
    input  logic [SEQ_W-1:0] set_seq,
    input  logic             clr_valid,
    input  logic             clr_full,
    input  logic [SEQ_W-1:0] clr_seq,
    output logic             ld_on,
    output logic [SEQ_W-1:0] ld_seq,
    output logic             st_on,
    output logic [SEQ_W-1:0] st_seq
);
    typedef struct packed {
        logic             ld_on;
        logic [SEQ_W-1:0] ld_seq;
        logic             st_on;
        logic [SEQ_W-1:0] st_seq;
    } bar_t;

    bar_t bar_d, bar_q;

    always_comb begin
        bar_d = bar_q;
        // release only when the completing fence is the one recorded
        if (clr_valid) begin
            if (clr_full && bar_q.ld_seq == clr_seq) bar_d.ld_on = 1'b0;
            if (bar_q.st_seq == clr_seq)             bar_d.st_on = 1'b0;
        end
        if (set_full) begin
            bar_d.ld_on  = 1'b1;
            bar_d.ld_seq = set_seq;
            bar_d.st_on  = 1'b1;
            bar_d.st_seq = set_seq;
        end else if (set_wr) begin
            bar_d.st_on  = 1'b1;
            bar_d.st_seq = set_seq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bar_q <= '0;
        else        bar_q <= bar_d;
    end

    assign ld_on  = bar_q.ld_on;
    assign ld_seq = bar_q.ld_seq;
    assign st_on  = bar_q.st_on;
    assign st_seq = bar_q.st_seq;

    // R6: an unmatched completion leaves the younger hold in place
    p_younger_ld_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && ld_on && ld_seq != clr_seq) |=> ld_on);
    p_younger_st_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && st_on && st_seq != clr_seq) |=> st_on);
    // R5: a write fence leaves the load hold untouched
    p_wbar_spares_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && !set_full && !(clr_valid && clr_full)) |=> (ld_on == $past(ld_on)));
endmodule

// File: rtl/mem_dep_tracker.sv
module mem_dep_tracker
    import mdu_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    output logic             ins_ready,
    input  logic [1:0]       ins_kind,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic             ins_regs_ok,
    output logic             pred_lookup_valid,
    output logic [PC_W-1:0]  pred_lookup_pc,
    input  logic [SEQ_W-1:0] pred_lookup_seq,
    output logic             st_rep_valid,
    output logic [PC_W-1:0]  st_rep_pc,
    output logic [SEQ_W-1:0] st_rep_seq,
    input  logic             viol_valid,
    input  logic [PC_W-1:0]  viol_load_pc,
    input  logic [PC_W-1:0]  viol_store_pc,
    output logic             pred_viol_valid,
    output logic [PC_W-1:0]  pred_viol_load_pc,
    output logic [PC_W-1:0]  pred_viol_store_pc,
    input  logic             regs_valid,
    input  logic [SEQ_W-1:0] regs_seq,
    input  logic             done_valid,
    input  logic [SEQ_W-1:0] done_seq,
    input  logic             resched_valid,
    input  logic [SEQ_W-1:0] resched_seq,
    input  logic             replay_req,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    output logic             pred_squash_valid,
    output logic [SEQ_W-1:0] pred_squash_seq,
    output logic             rdy_valid,
    output logic [SEQ_W-1:0] rdy_seq,
    output logic             rdy_is_store,
    input  logic             rdy_accept
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    typedef struct packed {
        logic             vld;
        kind_e            kind;
        logic [SEQ_W-1:0] seq;
        logic             regs;   // source registers ready
        logic             mem;    // memory dependence resolved
        logic             pend;   // waiting on the ready output
        logic             rep;    // parked for replay
        logic             pvld;   // linked to a producer
        logic [IDX_W-1:0] pidx;
    } ent_t;

    ent_t [N_ENT-1:0] tbl_d, tbl_q;

    function automatic logic is_mem(kind_e k);
        return (k == K_LOAD) || (k == K_STORE);
    endfunction

    kind_e ins_k;
    assign ins_k = kind_e'(ins_kind);

    // ---------------- table views ----------------
    logic [SEQ_W-1:0] seq_arr [N_ENT];
    logic [N_ENT-1:0] live_m, pend_m, sq_kill, prod_m;
    logic             full_q;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            seq_arr[i] = tbl_q[i].seq;
            live_m[i]  = tbl_q[i].vld;
            pend_m[i]  = tbl_q[i].vld && tbl_q[i].pend;
            sq_kill[i] = squash_valid && tbl_q[i].vld && (tbl_q[i].seq > squash_seq);
            if (!tbl_q[i].vld) free_idx = IDX_W'(i);
        end
    end
    assign full_q = &live_m;

    logic ins_fire;
    assign ins_ready = !full_q;
    assign ins_fire  = ins_valid && !full_q;

    // ---------------- fence holds ----------------
    logic             bar_ld_on, bar_st_on;
    logic [SEQ_W-1:0] bar_ld_seq, bar_st_seq;
    logic             done_hit, done_ok;
    logic [IDX_W-1:0] done_idx;
    kind_e            done_kind;

    mdu_seq_cam #(.N_ENT(N_ENT), .SEQ_W(SEQ_W)) u_cam_done (
        .elig(live_m), .seqs(seq_arr), .key(done_seq), .hit(done_hit), .idx(done_idx));

    assign done_ok   = done_valid && done_hit && !sq_kill[done_idx];
    assign done_kind = tbl_q[done_idx].kind;

    mdu_barrier_regs #(.SEQ_W(SEQ_W)) u_bar (
        .clk(clk), .rst_n(rst_n),
        .set_full(ins_fire && ins_k == K_FULLBAR),
        .set_wr(ins_fire && ins_k == K_WRBAR),
        .set_seq(ins_seq),
        .clr_valid(done_ok && !is_mem(done_kind)),
        .clr_full(done_kind == K_FULLBAR),
        .clr_seq(done_seq),
        .ld_on(bar_ld_on), .ld_seq(bar_ld_seq),
        .st_on(bar_st_on), .st_seq(bar_st_seq));

    // ---------------- producer selection ----------------
    logic [SEQ_W-1:0] prod_seq;
    logic             use_pred;

    always_comb begin
        use_pred = 1'b0;
        prod_seq = '0;
        if (ins_k == K_LOAD && bar_ld_on)       prod_seq = bar_ld_seq;
        else if (ins_k == K_STORE && bar_st_on) prod_seq = bar_st_seq;
        else if (is_mem(ins_k)) begin
            use_pred = 1'b1;
            prod_seq = pred_lookup_seq;
        end
    end

    // only stores and fences that survive this cycle can be producers
    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            prod_m[i] = tbl_q[i].vld && tbl_q[i].kind != K_LOAD && !sq_kill[i]
                        && !(done_ok && done_idx == IDX_W'(i));
        end
    end

    logic             prod_hit_raw, prod_hit;
    logic [IDX_W-1:0] prod_idx;
    mdu_seq_cam #(.N_ENT(N_ENT), .SEQ_W(SEQ_W)) u_cam_prod (
        .elig(prod_m), .seqs(seq_arr), .key(prod_seq), .hit(prod_hit_raw), .idx(prod_idx));
    assign prod_hit = prod_hit_raw && (prod_seq != '0);

    logic             regs_hit, rs_hit;
    logic [IDX_W-1:0] regs_idx, rs_idx;
    mdu_seq_cam #(.N_ENT(N_ENT), .SEQ_W(SEQ_W)) u_cam_regs (
        .elig(live_m), .seqs(seq_arr), .key(regs_seq), .hit(regs_hit), .idx(regs_idx));
    mdu_seq_cam #(.N_ENT(N_ENT), .SEQ_W(SEQ_W)) u_cam_rs (
        .elig(live_m), .seqs(seq_arr), .key(resched_seq), .hit(rs_hit), .idx(rs_idx));

    // ---------------- ready selection ----------------
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    mdu_oldest_pick #(.N_ENT(N_ENT), .SEQ_W(SEQ_W)) u_pick (
        .cand(pend_m), .seqs(seq_arr), .any(pick_any), .idx(pick_idx));

    assign rdy_valid    = pick_any;
    assign rdy_seq      = tbl_q[pick_idx].seq;
    assign rdy_is_store = tbl_q[pick_idx].kind == K_STORE;

    // ---------------- new entry ----------------
    ent_t new_ent;
    always_comb begin
        new_ent      = '0;
        new_ent.vld  = 1'b1;
        new_ent.kind = ins_k;
        new_ent.seq  = ins_seq;
        new_ent.regs = ins_regs_ok;
        new_ent.pvld = prod_hit;
        new_ent.pidx = prod_idx;
        new_ent.mem  = !prod_hit;
        new_ent.pend = !prod_hit && ins_regs_ok && is_mem(ins_k);
    end

    // ---------------- next state, in event order ----------------
    always_comb begin
        tbl_d = tbl_q;
        if (pick_any && rdy_accept) tbl_d[pick_idx].pend = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (sq_kill[i]) tbl_d[i] = '0;
        end
        if (done_ok) begin
            if (done_kind != K_LOAD) begin
                for (int j = 0; j < N_ENT; j++) begin
                    if (tbl_d[j].vld && tbl_d[j].pvld && tbl_d[j].pidx == done_idx) begin
                        tbl_d[j].pvld = 1'b0;
                        tbl_d[j].mem  = 1'b1;
                        if (tbl_d[j].regs && is_mem(tbl_d[j].kind)) tbl_d[j].pend = 1'b1;
                    end
                end
            end
            tbl_d[done_idx] = '0;
        end
        if (regs_valid && regs_hit && tbl_d[regs_idx].vld) begin
            tbl_d[regs_idx].regs = 1'b1;
            if (tbl_d[regs_idx].mem && is_mem(tbl_d[regs_idx].kind))
                tbl_d[regs_idx].pend = 1'b1;
        end
        if (resched_valid && rs_hit && tbl_d[rs_idx].vld && is_mem(tbl_d[rs_idx].kind)) begin
            tbl_d[rs_idx].rep  = 1'b1;
            tbl_d[rs_idx].pend = 1'b0;
        end
        if (replay_req) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (tbl_d[i].vld && tbl_d[i].rep) begin
                    tbl_d[i].rep  = 1'b0;
                    tbl_d[i].pend = 1'b1;
                end
            end
        end
        if (ins_fire) tbl_d[free_idx] = new_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // ---------------- predictor side ----------------
    assign pred_lookup_valid  = ins_fire && use_pred;
    assign pred_lookup_pc     = ins_pc;
    assign st_rep_valid       = ins_fire && ins_k == K_STORE;
    assign st_rep_pc          = ins_pc;
    assign st_rep_seq         = ins_seq;
    assign pred_viol_valid    = viol_valid;
    assign pred_viol_load_pc  = viol_load_pc;
    assign pred_viol_store_pc = viol_store_pc;
    assign pred_squash_valid  = squash_valid;
    assign pred_squash_seq    = squash_seq;

    // ---------------- assertions ----------------
    // R10: an offer persists until taken (unless the entry is removed)
    p_offer_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_valid && !rdy_accept && !squash_valid && !done_valid) |=> rdy_valid);
    // R13: the offered entry is always a load or store
    p_no_fence_offer_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid |-> (tbl_q[pick_idx].kind == K_LOAD || tbl_q[pick_idx].kind == K_STORE));

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent_chk
        // R3: a linked entry is never waiting on the ready output
        p_linked_not_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(tbl_q[g].vld && tbl_q[g].pvld && tbl_q[g].pend));
        // R8: nothing younger than the squash number survives
        p_squash_removes_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (squash_valid && !ins_fire) |=> !(tbl_q[g].vld && tbl_q[g].seq > $past(squash_seq)));
    end
endmodule

// File: tb/tb_mem_dep_tracker.sv
module tb_mem_dep_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int N_ENT = 16;
    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic             i_ins_v = 0, i_regs = 0, i_vl_v = 0, i_rg_v = 0, i_dn_v = 0;
    logic             i_rs_v = 0, i_rp = 0, i_sq_v = 0, i_acc = 0;
    logic [1:0]       i_kind = 0;
    logic [SEQ_W-1:0] i_seq = 0, pred_ans = 0, i_rg_s = 0, i_dn_s = 0, i_rs_s = 0, i_sq_n = 0;
    logic [PC_W-1:0]  i_pc = 0, i_vl_l = 0, i_vl_s = 0;

    logic             ins_ready, pred_lookup_valid, st_rep_valid, pred_viol_valid;
    logic             pred_squash_valid, rdy_valid, rdy_is_store;
    logic [PC_W-1:0]  pred_lookup_pc, st_rep_pc, pred_viol_load_pc, pred_viol_store_pc;
    logic [SEQ_W-1:0] st_rep_seq, pred_squash_seq, rdy_seq;

    mem_dep_tracker #(.N_ENT(N_ENT), .SEQ_W(SEQ_W), .PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(i_ins_v), .ins_ready(ins_ready), .ins_kind(i_kind), .ins_seq(i_seq),
        .ins_pc(i_pc), .ins_regs_ok(i_regs),
        .pred_lookup_valid(pred_lookup_valid), .pred_lookup_pc(pred_lookup_pc),
        .pred_lookup_seq(pred_ans),
        .st_rep_valid(st_rep_valid), .st_rep_pc(st_rep_pc), .st_rep_seq(st_rep_seq),
        .viol_valid(i_vl_v), .viol_load_pc(i_vl_l), .viol_store_pc(i_vl_s),
        .pred_viol_valid(pred_viol_valid), .pred_viol_load_pc(pred_viol_load_pc),
        .pred_viol_store_pc(pred_viol_store_pc),
        .regs_valid(i_rg_v), .regs_seq(i_rg_s), .done_valid(i_dn_v), .done_seq(i_dn_s),
        .resched_valid(i_rs_v), .resched_seq(i_rs_s), .replay_req(i_rp),
        .squash_valid(i_sq_v), .squash_seq(i_sq_n),
        .pred_squash_valid(pred_squash_valid), .pred_squash_seq(pred_squash_seq),
        .rdy_valid(rdy_valid), .rdy_seq(rdy_seq), .rdy_is_store(rdy_is_store),
        .rdy_accept(i_acc));

    int n_cmp = 0;
    int n_bad = 0;

    // ---------------- behavioural reference ----------------
    typedef struct {
        int seq; int kind; bit regs; bit mem; bit pend; bit rep; int prod;
    } ment_t;
    ment_t tab[$];
    bit m_ld_on = 0, m_st_on = 0;
    int m_ld_sq = 0, m_st_sq = 0;

    function automatic int m_find(int s);
        foreach (tab[i]) if (tab[i].seq == s) return i;
        return -1;
    endfunction

    function automatic int m_pick();
        int b = -1;
        foreach (tab[i]) if (tab[i].pend && (b < 0 || tab[i].seq < tab[b].seq)) b = i;
        return b;
    endfunction

    task automatic cmp(int act, int exp, string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare();
        int p = m_pick();
        bit lk = i_ins_v && tab.size() < N_ENT &&
                 ((i_kind == 0 && !m_ld_on) || (i_kind == 1 && !m_st_on));
        cmp(ins_ready, tab.size() < N_ENT, "R1 ins_ready");
        cmp(rdy_valid, p >= 0, "R10 rdy_valid");
        if (p >= 0) cmp(rdy_seq, tab[p].seq, "R10 rdy_seq");
        cmp(pred_lookup_valid, lk, "R4 pred_lookup_valid");
        cmp(st_rep_valid, i_ins_v && tab.size() < N_ENT && i_kind == 1, "R11 st_rep_valid");
    endtask

    task automatic model_step();
        int  sel = m_pick();
        bit  o_ld = m_ld_on, o_st = m_st_on;
        int  o_lds = m_ld_sq, o_sts = m_st_sq;
        bit  can_ins = tab.size() < N_ENT;
        if (i_acc && sel >= 0) tab[sel].pend = 0;
        if (i_sq_v)
            for (int i = tab.size() - 1; i >= 0; i--)
                if (tab[i].seq > int'(i_sq_n)) tab.delete(i);
        if (i_dn_v) begin
            int d = m_find(int'(i_dn_s));
            if (d >= 0) begin
                int k = tab[d].kind;
                if (k != 0)
                    foreach (tab[j])
                        if (tab[j].prod == int'(i_dn_s)) begin
                            tab[j].prod = 0;
                            tab[j].mem  = 1;
                            if (tab[j].regs && tab[j].kind < 2) tab[j].pend = 1;
                        end
                if (k == 2 && m_ld_sq == int'(i_dn_s)) m_ld_on = 0;
                if (k >= 2 && m_st_sq == int'(i_dn_s)) m_st_on = 0;
                tab.delete(d);
            end
        end
        if (i_rg_v) begin
            int r = m_find(int'(i_rg_s));
            if (r >= 0) begin
                tab[r].regs = 1;
                if (tab[r].mem && tab[r].kind < 2) tab[r].pend = 1;
            end
        end
        if (i_rs_v) begin
            int r = m_find(int'(i_rs_s));
            if (r >= 0 && tab[r].kind < 2) begin tab[r].rep = 1; tab[r].pend = 0; end
        end
        if (i_rp)
            foreach (tab[i]) if (tab[i].rep) begin tab[i].rep = 0; tab[i].pend = 1; end
        if (i_ins_v && can_ins) begin
            int p = 0;
            int pi = -1;
            ment_t e;
            if (i_kind == 0 && o_ld)      p = o_lds;
            else if (i_kind == 1 && o_st) p = o_sts;
            else if (i_kind < 2)          p = int'(pred_ans);
            if (p != 0) begin
                pi = m_find(p);
                if (pi >= 0 && tab[pi].kind == 0) pi = -1;
            end
            e.seq = int'(i_seq); e.kind = int'(i_kind); e.regs = i_regs; e.rep = 0;
            if (pi >= 0) begin e.mem = 0; e.pend = 0; e.prod = p; end
            else begin e.mem = 1; e.pend = i_regs && i_kind < 2; e.prod = 0; end
            tab.push_back(e);
            if (i_kind == 2) begin
                m_ld_on = 1; m_ld_sq = int'(i_seq); m_st_on = 1; m_st_sq = int'(i_seq);
            end else if (i_kind == 3) begin
                m_st_on = 1; m_st_sq = int'(i_seq);
            end
        end
    endtask

    task automatic cyc();
        #1 compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
        i_ins_v = 0; i_rg_v = 0; i_dn_v = 0; i_rs_v = 0; i_rp = 0; i_sq_v = 0; i_vl_v = 0;
    endtask

    task automatic ins(int k, int s, bit r, int pa);
        i_ins_v = 1; i_kind = 2'(k); i_seq = SEQ_W'(s); i_regs = r;
        i_pc = PC_W'(32'h1000 + s * 4); pred_ans = SEQ_W'(pa);
        cyc();
    endtask
    task automatic take();  i_acc = 1; cyc(); i_acc = 0; endtask
    task automatic fin(int s); i_dn_v = 1; i_dn_s = SEQ_W'(s); cyc(); endtask
    task automatic rgo(int s); i_rg_v = 1; i_rg_s = SEQ_W'(s); cyc(); endtask
    task automatic sq(int n);  i_sq_v = 1; i_sq_n = SEQ_W'(n); cyc(); endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog expired R10 actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        cmp(ins_ready, 1, "R1 reset ins_ready");
        cmp(rdy_valid, 0, "R1 reset rdy_valid");
        @(negedge clk);

        // R2: no dependence, registers ready -> offered next cycle
        ins(0, 1, 1, 0);
        cmp(rdy_valid, 1, "R2 immediate ready");
        cmp(rdy_seq, 1, "R2 seq");
        take(); fin(1);

        // R3: dependent held until producer completes
        ins(1, 2, 1, 0); take();
        ins(0, 3, 0, 2);
        rgo(3);
        cmp(rdy_valid, 0, "R3 held by producer");
        fin(2);
        cmp(rdy_seq, 3, "R3 released on completion");
        take(); fin(3);

        // R10: oldest first and hold
        ins(0, 21, 0, 0);
        ins(0, 22, 1, 0);
        cyc();
        cmp(rdy_seq, 22, "R10 held without accept");
        rgo(21);
        cmp(rdy_seq, 21, "R10 oldest wins");
        take();
        cmp(rdy_seq, 22, "R10 next");
        take(); fin(21); fin(22);

        // R4: full fence overrides predictor
        ins(2, 30, 1, 0);
        i_ins_v = 1; i_kind = 2'd0; i_seq = 31; i_regs = 1; pred_ans = 99;
        #1 cmp(pred_lookup_valid, 0, "R4 no lookup under fence");
        cyc();
        ins(1, 32, 1, 0);
        cmp(rdy_valid, 0, "R4 held by fence");
        fin(30);
        cmp(rdy_seq, 31, "R4 release load");
        take(); take(); fin(31); fin(32);

        // R5: write fence holds only stores
        ins(3, 40, 0, 0);
        ins(0, 41, 1, 0);
        cmp(rdy_seq, 41, "R5 load passes write fence");
        take();
        ins(1, 42, 1, 0);
        cmp(rdy_valid, 0, "R5 store held");
        fin(40);
        cmp(rdy_seq, 42, "R5 store released");
        take(); fin(41); fin(42);

        // R6: younger fence keeps its hold
        ins(2, 50, 0, 0);
        ins(2, 51, 0, 0);
        fin(50);
        ins(0, 52, 1, 0);
        cmp(rdy_valid, 0, "R6 younger fence holds");
        fin(51);
        cmp(rdy_seq, 52, "R6 released by matching fence");
        take();
        ins(0, 53, 1, 0);
        cmp(rdy_seq, 53, "R6 holds cleared");
        take(); fin(52); fin(53);

        // R12: producer completes in the insert cycle
        ins(1, 60, 0, 0);
        i_dn_v = 1; i_dn_s = 60;
        ins(0, 61, 1, 60);
        cmp(rdy_seq, 61, "R12 same-cycle completion");
        take(); fin(61);

        // R9: reschedule and replay
        ins(0, 70, 1, 0); take();
        i_rs_v = 1; i_rs_s = 70; cyc();
        cmp(rdy_valid, 0, "R9 parked not offered");
        ins(1, 71, 1, 0); take();
        i_rs_v = 1; i_rs_s = 71; cyc();
        i_rp = 1; cyc();
        cmp(rdy_seq, 70, "R9 replay first");
        take();
        cmp(rdy_seq, 71, "R9 replay second");
        take(); fin(70); fin(71);

        // R8: squash removes younger pending entries
        ins(0, 80, 1, 0);
        ins(0, 81, 1, 0);
        ins(0, 82, 1, 0);
        i_sq_v = 1; i_sq_n = 80;
        #1 cmp(pred_squash_valid, 1, "R8 squash forwarded");
        cmp(pred_squash_seq, 80, "R8 squash number");
        cyc();
        cmp(rdy_seq, 80, "R8 survivor");
        take();
        cmp(rdy_valid, 0, "R8 younger gone");
        fin(80);

        // R7: a load is not a producer
        ins(0, 120, 0, 0);
        ins(1, 121, 1, 120);
        cmp(rdy_seq, 121, "R7 load not a producer");
        take(); fin(120); fin(121);

        // R13: fences never offered
        ins(2, 130, 1, 0);
        rgo(130);
        cmp(rdy_valid, 0, "R13 fence not offered");
        fin(130);

        // R11: store report and violation forward
        i_ins_v = 1; i_kind = 2'd1; i_seq = 140; i_regs = 1; i_pc = 32'h0000_7740; pred_ans = 0;
        #1 cmp(st_rep_pc, 32'h0000_7740, "R11 store pc");
        cmp(st_rep_seq, 140, "R11 store seq");
        cyc();
        i_vl_v = 1; i_vl_l = 32'h0000_0111; i_vl_s = 32'h0000_0222;
        #1 cmp(pred_viol_valid, 1, "R11 violation valid");
        cmp(pred_viol_load_pc, 32'h0000_0111, "R11 violation load pc");
        cmp(pred_viol_store_pc, 32'h0000_0222, "R11 violation store pc");
        cyc();
        sq(0);

        // R1: fill, drop insert when full
        for (int s = 200; s < 200 + N_ENT; s++) ins(1, s, 0, 0);
        cmp(ins_ready, 0, "R1 full");
        ins(0, 216, 1, 0);
        cyc();
        cmp(rdy_valid, 0, "R1 dropped insert");
        sq(0);
        cmp(ins_ready, 1, "R1 drained");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule